// File: doc/BRIEF.md
# Swapping Address Unit for a Small Microcoded Processor

This block generates memory addresses for a very small processor without a multiplexer between the program counter and the data address register. The two registers sit in a ring. The register in the front slot always drives the memory address. The back slot is loaded from the front slot through a single adder that adds 0 or 1. On a swap, the front slot takes the back slot's value and the back slot takes the front value plus the increment bit. Each instruction swaps the pair twice. The program counter is therefore in front for the opcode fetch, the data address is in front for the operand access, and the program counter is back in front for the next fetch.

A four-phase state machine sequences one instruction. The phases are FETCH (code 0), SWAP_A (code 1), DATA (code 2) and SWAP_B (code 3). A phase advances only when `step` is high at a clock edge. The transitions are FETCH→SWAP_A, SWAP_A→DATA, DATA→SWAP_B and SWAP_B→FETCH. During the SWAP_A transition the program counter passes through the adder with +1. During the SWAP_B transition the data address passes through with +0, or with +1 if the instruction asks for auto-increment, which gives a post-increment. During SWAP_A a load request can replace the incoming data address with a value from the data bus. The surrounding processor is told through `fetch_cyc` and `data_cyc` which kind of access the present address is for.

Top module: `swap_addr_unit`

## Requirements
- R1: After reset, `mem_addr` is 0, `phase` is 0 (FETCH), `fetch_cyc` is 1 and `data_cyc` is 0. The data address also starts at 0, so the first DATA phase without a load presents 0.
- R2: With `step` high at an edge, the phase moves 0→1→2→3→0. With `step` low, `phase` and `mem_addr` keep their values.
- R3: Each instruction's FETCH address is the previous FETCH address plus 1, modulo 2^ADDR_W. 255 is followed by 0 at the default width.
- R4: During SWAP_A, `mem_addr` still shows the fetch address. During DATA and SWAP_B, it shows the data address. Without a load or auto-increment, the data address carries over unchanged to the next instruction.
- R5: If `auto_inc` is high at the step edge that leaves SWAP_B, the next instruction's data address is the current one plus 1, wrapping from all-ones to 0. Otherwise it is unchanged.
- R6: If `ld_ar` is high at the step edge that leaves SWAP_A, the DATA phase presents `ld_data`. The program counter still advances by 1.
- R7: `ld_ar` has no effect in phases other than SWAP_A, and `auto_inc` has no effect in phases other than SWAP_B.
- R8: `fetch_cyc` is high exactly in FETCH, `data_cyc` is high exactly in DATA, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance to the next phase at this edge |
| ld_ar | input | 1 | Replace the data address during SWAP_A |
| ld_data | input | ADDR_W | New data address value |
| auto_inc | input | 1 | Post-increment the data address during SWAP_B |
| mem_addr | output | ADDR_W | Memory address, always the front ring slot |
| phase | output | 2 | Current phase: 0 FETCH, 1 SWAP_A, 2 DATA, 3 SWAP_B |
| fetch_cyc | output | 1 | Current address is an instruction fetch |
| data_cyc | output | 1 | Current address is a data access |

## Verification
The bench targets the wrap of both registers at all-ones. A ring that widened or saturated would fetch 256 or stick at 255 instead of returning to 0. It drives `ld_ar` and `auto_inc` high in every phase where they must be ignored. A decoder that took them in the wrong phase would corrupt the program counter or shift the data address by one. It holds `step` low in the middle of an instruction, where a sequencer that runs freely would swap the registers out of order. A post-increment mistakenly applied on the first swap would show up as a fetch address that skips one.

// File: rtl/swap_addr_pkg.sv
package swap_addr_pkg;
    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_SWAP_A = 2'd1,
        PH_DATA   = 2'd2,
        PH_SWAP_B = 2'd3
    } phase_e;
endpackage

// File: rtl/swap_inc_adder.sv
module swap_inc_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         inc,
    output logic [W-1:0] sum
);
    // Only carry-in is variable: an incrementer, wrapping modulo 2^W.
    assign sum = a + {{(W-1){1'b0}}, inc};
endmodule

// File: rtl/swap_phase_seq.sv
module swap_phase_seq
    import swap_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    input  logic   ld_req,
    input  logic   auto_inc,
    output phase_e phase_o,
    output logic   swap_en,
    output logic   load_en,
    output logic   inc_bit,
    output logic   fetch_cyc,
    output logic   data_cyc
);
    phase_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                PH_FETCH:  state_d = PH_SWAP_A;
                PH_SWAP_A: state_d = PH_DATA;
                PH_DATA:   state_d = PH_SWAP_B;
                PH_SWAP_B: state_d = PH_FETCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_FETCH;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        swap_en   = 1'b0;
        load_en   = 1'b0;
        inc_bit   = 1'b0;
        fetch_cyc = 1'b0;
        data_cyc  = 1'b0;
        unique case (state_q)
            PH_FETCH:  fetch_cyc = 1'b1;
            PH_SWAP_A: begin
                swap_en = step;
                load_en = step & ld_req;
                inc_bit = 1'b1;          // program counter leaves the front slot
            end
            PH_DATA:   data_cyc = 1'b1;
            PH_SWAP_B: begin
                swap_en = step;
                inc_bit = auto_inc;      // data address leaves the front slot
            end
        endcase
    end

    assign phase_o = state_q;

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == PH_SWAP_B) |=> state_q == PH_FETCH);
    assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_cyc && data_cyc));
endmodule

// File: rtl/swap_ring.sv
module swap_ring #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         swap_en,
    input  logic         load_en,
    input  logic         inc_bit,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] front_o
);
    logic [W-1:0] front_q, back_q, adder_out;

    swap_inc_adder #(.W(W)) u_adder (
        .a   (front_q),
        .inc (inc_bit),
        .sum (adder_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_q <= '0;
            back_q  <= '0;
        end else if (swap_en) begin
            back_q  <= adder_out;
            front_q <= load_en ? load_val : back_q;
        end
    end

    assign front_o = front_q;

    assert_front_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en |=> $stable(front_q));
endmodule

// File: rtl/swap_addr_unit.sv
module swap_addr_unit
    import swap_addr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld_ar,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              auto_inc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        phase,
    output logic              fetch_cyc,
    output logic              data_cyc
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    phase_e ph;
    logic   swap_en, load_en, inc_bit;

    swap_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .ld_req    (ld_ar),
        .auto_inc  (auto_inc),
        .phase_o   (ph),
        .swap_en   (swap_en),
        .load_en   (load_en),
        .inc_bit   (inc_bit),
        .fetch_cyc (fetch_cyc),
        .data_cyc  (data_cyc)
    );

    swap_ring #(.W(ADDR_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_en  (swap_en),
        .load_en  (load_en),
        .inc_bit  (inc_bit),
        .load_val (ld_data),
        .front_o  (mem_addr)
    );

    assign phase = ph;

    // Shadow of the last fetch address, for checking the program counter.
    logic [ADDR_W-1:0] last_fetch_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_fetch_q <= '1;
        else if (fetch_cyc && step)  last_fetch_q <= mem_addr;
    end

    assert_pc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_cyc) |-> mem_addr == last_fetch_q + ONE);
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(mem_addr));
endmodule

// File: tb/swap_addr_unit_test.sv
module swap_addr_unit_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step = 1'b0;
    logic         ld_ar = 1'b0;
    logic [W-1:0] ld_data = '0;
    logic         auto_inc = 1'b0;
    logic [W-1:0] mem_addr;
    logic [1:0]   phase;
    logic         fetch_cyc, data_cyc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    swap_addr_unit #(.ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .step(step), .ld_ar(ld_ar), .ld_data(ld_data),
        .auto_inc(auto_inc), .mem_addr(mem_addr), .phase(phase),
        .fetch_cyc(fetch_cyc), .data_cyc(data_cyc)
    );

    // {ld, ld_value, auto_inc, expected fetch addr, expected data addr}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
        {1'b1, 8'h40, 1'b1, 8'h01, 8'h40},
        {1'b0, 8'h00, 1'b1, 8'h02, 8'h41},
        {1'b0, 8'h00, 1'b0, 8'h03, 8'h42},
        {1'b1, 8'hFF, 1'b1, 8'h04, 8'hFF},
        {1'b0, 8'h00, 1'b0, 8'h05, 8'h00},
        {1'b1, 8'h7A, 1'b0, 8'h06, 8'h7A},
        {1'b0, 8'h00, 1'b1, 8'h07, 8'h7A}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One instruction; inputs that must be ignored are driven high in the wrong phases (R7).
    task automatic run_instr(input logic ld, input logic [W-1:0] ldv, input logic ai,
                             input logic [W-1:0] exp_f, input logic [W-1:0] exp_d,
                             input bit full);
        @(negedge clk);
        if (full) begin
            chk("R2 phase fetch", phase, 0);
            chk("R8 fetch_cyc", {fetch_cyc, data_cyc}, 2'b10);
        end
        chk("R3 fetch addr", mem_addr, exp_f);
        step = 1; ld_ar = 1; ld_data = 8'h55; auto_inc = 1;
        @(negedge clk);
        if (full) begin
            chk("R2 phase swap_a", phase, 1);
            chk("R4 addr in swap_a", mem_addr, exp_f);
        end
        ld_ar = ld; ld_data = ldv; auto_inc = 1;
        @(negedge clk);
        chk("R6/R4 data addr", mem_addr, exp_d);
        if (full) chk("R8 data_cyc", {phase, fetch_cyc, data_cyc}, 4'b1001);
        ld_ar = 1; ld_data = 8'h33; auto_inc = 1;
        @(negedge clk);
        if (full) chk("R7 addr in swap_b", {phase, mem_addr}, {2'd3, exp_d});
        ld_ar = 1; ld_data = 8'h99; auto_inc = ai;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pc, ar;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 reset addr", mem_addr, 0);
        chk("R1 reset phase", phase, 0);
        chk("R1 reset flags", {fetch_cyc, data_cyc}, 2'b10);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            run_instr(v[25], v[24:17], v[16], v[15:8], v[7:0], 1);
        end
        pc = 8'h08; ar = 8'h7B;

        // R2 stall in the middle of an instruction
        @(negedge clk);
        chk("R3 fetch after table", mem_addr, pc);
        step = 1; ld_ar = 0; auto_inc = 0;
        @(negedge clk);
        step = 0; ld_ar = 1; auto_inc = 1;
        repeat (3) begin
            @(negedge clk);
            chk("R2 stall phase", phase, 1);
            chk("R2 stall addr", mem_addr, pc);
        end
        step = 1; ld_ar = 0;
        @(negedge clk);
        chk("R2 resume data", {phase, mem_addr}, {2'd2, ar});
        auto_inc = 1;
        @(negedge clk);
        auto_inc = 0;
        pc = pc + 1;
        // R4 data address carries over unchanged
        run_instr(0, 0, 0, pc, ar, 1);
        pc = pc + 1;

        // R3 program counter wrap: run up to fetch 0xFF
        while (pc != 8'hFF) begin
            run_instr(0, 0, 0, pc, ar, 0);
            pc = pc + 1;
        end
        run_instr(1, 8'hFF, 1, 8'hFF, 8'hFF, 1);
        // R5 data address wraps 0xFF -> 0x00; R3 pc wraps 0xFF -> 0x00
        run_instr(0, 0, 0, 8'h00, 8'h00, 1);
        @(negedge clk);
        chk("R3 fetch after wrap", mem_addr, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule